// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the instruction address of a single-cycle processor and chooses its value for the following cycle. On every clock edge the address either moves on by one instruction (four bytes) or is redirected by a PC-relative branch. Three branch forms are supported. The first is unconditional. The second is taken on a signed less-than condition from the flags. The third is taken when a tested register reads zero.

The decoder supplies a two-bit branch kind and the branch offset. The offset arrives already scaled to bytes and sign-extended to the full address width. The unconditional form carries a wider immediate field than the two conditional forms, and the decoder takes care of that difference. The flag logic supplies the less-than condition, which is negative differing from overflow. The register file side supplies the zero indication. Every target is the address of the branch instruction itself plus the offset. A taken branch changes the fetch address on the very next cycle, so the instruction after the branch is never fetched.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` becomes 0 after that edge. This holds whatever the other inputs are, including a branch request.
- R2: With `br_kind` = 2'b00 (no branch), the next `pc` is the current `pc` plus 4, even when `br_off` is nonzero.
- R3: With `br_kind` = 2'b01 (unconditional), the next `pc` is the current `pc` plus `br_off`.
- R4: With `br_kind` = 2'b10 (less-than branch) and `lt_cond` high, the next `pc` is the current `pc` plus `br_off`.
- R5: With `br_kind` = 2'b10 and `lt_cond` low, the next `pc` is the current `pc` plus 4 for any `br_off`.
- R6: With `br_kind` = 2'b11 (zero branch) and `reg_is_zero` high, the next `pc` is the current `pc` plus `br_off`.
- R7: With `br_kind` = 2'b11 and `reg_is_zero` low, the next `pc` is the current `pc` plus 4 for any `br_off`.
- R8: A branch target is the branch's own address plus the two's-complement offset, taken modulo 2^64. A negative offset therefore moves the address backwards.
- R9: A taken branch redirects on the next cycle with no delay slot. The address that follows the branch is the target, not the branch address plus 4.
- R10: A condition input that the selected kind does not use has no effect. An unconditional branch ignores both `lt_cond` and `reg_is_zero`. The less-than kind ignores `reg_is_zero`. The zero kind ignores `lt_cond`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| br_kind | input | 2 | Branch kind: 00 none, 01 always, 10 less-than, 11 register zero |
| br_off | input | 64 | Byte offset, pre-scaled and sign-extended |
| lt_cond | input | 1 | Signed less-than condition (negative differs from overflow) |
| reg_is_zero | input | 1 | Tested register reads zero |
| pc | output | 64 | Current instruction fetch address |

## Verification
The alignment assertion assumes that every offset the decoder supplies is a multiple of four. Since the reset address is zero, the address then always stays word aligned. Random offsets in the bench are built from a signed immediate with its two low bits cleared, so this assumption always holds. Those immediates are 26 bits wide after scaling to 28 for the unconditional kind, and 19 bits wide after scaling to 21 for the conditional kinds, matching what a decoder would produce. The per-kind assertions treat the branch kind and both conditions as settled at each rising edge. The bench changes inputs only on falling edges, which keeps that assumption true.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

    typedef enum logic [1:0] {
        BRK_NONE   = 2'b00,
        BRK_ALWAYS = 2'b01,
        BRK_LT     = 2'b10,
        BRK_ZERO   = 2'b11
    } br_kind_e;

endpackage

// File: rtl/nextpc_cond.sv
module nextpc_cond
    import nextpc_pkg::*;
(
    input  br_kind_e kind,
    input  logic     lt_cond,
    input  logic     reg_is_zero,
    output logic     take
);

    always_comb begin
        unique case (kind)
            BRK_ALWAYS: take = 1'b1;
            BRK_LT:     take = lt_cond;
            BRK_ZERO:   take = reg_is_zero;
            default:    take = 1'b0;
        endcase
    end

endmodule

// File: rtl/nextpc_adder.sv
module nextpc_adder #(
    parameter int W = 64
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] addend,
    output logic [W-1:0] sum
);

    always_comb begin
        sum = base + addend;
    end

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter int          ADDR_W     = 64,
    parameter int          STEP       = 4,
    parameter logic [63:0] RESET_ADDR = 64'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        br_kind,
    input  logic [ADDR_W-1:0] br_off,
    input  logic              lt_cond,
    input  logic              reg_is_zero,
    output logic [ADDR_W-1:0] pc
);

    localparam logic [ADDR_W-1:0] STEP_V  = ADDR_W'(STEP);
    localparam logic [ADDR_W-1:0] RESET_V = RESET_ADDR[ADDR_W-1:0];

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;

    pc_state_t         st_d, st_q;
    br_kind_e          kind_d;
    logic              take_d;
    logic [ADDR_W-1:0] seq_addr_d;
    logic [ADDR_W-1:0] tgt_addr_d;

    assign kind_d = br_kind_e'(br_kind);

    nextpc_cond u_cond (
        .kind        (kind_d),
        .lt_cond     (lt_cond),
        .reg_is_zero (reg_is_zero),
        .take        (take_d)
    );

    nextpc_adder #(.W(ADDR_W)) u_seq_add (
        .base   (st_q.pc),
        .addend (STEP_V),
        .sum    (seq_addr_d)
    );

    nextpc_adder #(.W(ADDR_W)) u_tgt_add (
        .base   (st_q.pc),
        .addend (br_off),
        .sum    (tgt_addr_d)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = RESET_V;
        end else if (take_d) begin
            st_d.pc = tgt_addr_d;
        end else begin
            st_d.pc = seq_addr_d;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc = st_q.pc;

    AST_RESET_ADDR: assert property (@(posedge clk) rst |=> (rst || pc == RESET_V)); // R1

    AST_NONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b00) |=> pc == $past(pc) + STEP_V); // R2

    AST_ALWAYS_JUMP: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b01) |=> pc == $past(pc) + $past(br_off)); // R3

    AST_LT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b10 && lt_cond) |=> pc == $past(pc) + $past(br_off)); // R4

    AST_LT_SKIP: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b10 && !lt_cond) |=> pc == $past(pc) + STEP_V); // R5

    AST_ZERO_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b11 && reg_is_zero) |=> pc == $past(pc) + $past(br_off)); // R6

    AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b11 && !reg_is_zero) |=> pc == $past(pc) + STEP_V); // R7

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (br_off[1:0] == 2'b00) |=> pc[1:0] == 2'b00); // R8

endmodule

// File: tb/nextpc_unit_tb.sv
module nextpc_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  br_kind;
    logic [63:0] br_off;
    logic        lt_cond;
    logic        reg_is_zero;
    logic [63:0] pc;

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [63:0] exp_pc;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    nextpc_unit u_dut (
        .clk         (clk),
        .rst         (rst),
        .br_kind     (br_kind),
        .br_off      (br_off),
        .lt_cond     (lt_cond),
        .reg_is_zero (reg_is_zero),
        .pc          (pc)
    );

    function automatic logic [63:0] model_next(logic [63:0] cur, logic r, logic [1:0] k,
                                               logic [63:0] o, logic l, logic z);
        if (r) return 64'd0;
        case (k)
            2'b01:   return cur + o;
            2'b10:   return l ? cur + o : cur + 64'd4;
            2'b11:   return z ? cur + o : cur + 64'd4;
            default: return cur + 64'd4;
        endcase
    endfunction

    function automatic string tag_of(logic r, logic [1:0] k, logic l, logic z);
        if (r) return "R1";
        case (k)
            2'b01:   return "R3";
            2'b10:   return l ? "R4" : "R5";
            2'b11:   return z ? "R6" : "R7";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [63:0] rand_off(bit wide);
        logic [31:0] r;
        r = $urandom;
        if (wide) return {{36{r[27]}}, r[27:2], 2'b00};
        return {{43{r[20]}}, r[20:2], 2'b00};
    endfunction

    task automatic check(logic [63:0] act, logic [63:0] exp, string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pc actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(logic r, logic [1:0] k, logic [63:0] o, logic l, logic z, string tag);
        logic [63:0] nxt;
        rst = r; br_kind = k; br_off = o; lt_cond = l; reg_is_zero = z;
        nxt = model_next(exp_pc, r, k, o, l, z);
        @(posedge clk);
        @(negedge clk);
        check(pc, nxt, (tag == "") ? tag_of(r, k, l, z) : tag);
        exp_pc = nxt;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; br_kind = 2'b00; br_off = '0; lt_cond = 1'b0; reg_is_zero = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pc, 64'd0, "R1");
        exp_pc = 64'd0;

        step(1'b0, 2'b00, 64'h1000, 1'b1, 1'b1, "R2");
        step(1'b0, 2'b00, 64'd0,    1'b0, 1'b0, "R2");
        step(1'b0, 2'b01, 64'd40,   1'b0, 1'b0, "R3");
        step(1'b0, 2'b01, 64'd12,   1'b0, 1'b0, "R9");
        step(1'b0, 2'b00, 64'd0,    1'b0, 1'b0, "R9");
        step(1'b0, 2'b01, -64'sd16, 1'b0, 1'b0, "R8");
        step(1'b0, 2'b10, 64'd64,   1'b1, 1'b0, "R4");
        step(1'b0, 2'b10, 64'd64,   1'b0, 1'b1, "R5");
        step(1'b0, 2'b11, -64'sd8,  1'b0, 1'b1, "R6");
        step(1'b0, 2'b11, 64'd200,  1'b1, 1'b0, "R7");
        step(1'b0, 2'b01, 64'd8,    1'b1, 1'b1, "R10");
        step(1'b0, 2'b10, 64'd8,    1'b0, 1'b1, "R10");
        step(1'b0, 2'b11, 64'd8,    1'b1, 1'b0, "R10");
        step(1'b0, 2'b01, -64'sd4096, 1'b0, 1'b0, "R8");
        step(1'b1, 2'b01, 64'd400,  1'b1, 1'b1, "R1");
        step(1'b0, 2'b01, -64'sd4,  1'b0, 1'b0, "R8");

        for (int i = 0; i < 3000; i++) begin
            logic [1:0] k;
            logic r;
            k = 2'($urandom_range(0, 3));
            r = ($urandom_range(0, 99) == 0);
            step(r, k, rand_off(k == 2'b01), 1'($urandom), 1'($urandom), "");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule